// File: doc/BRIEF.md
# Host FIFO Burst-Read Port

This block is the read side of an asynchronous host bus, modelled synchronously. It drains a receive-data FIFO. The host drives two active-low strobes, chip-select and read-enable. Each strobe passes through a two-flop synchronizer. A read cycle is the interval in which both synchronized strobes are low. The two strobes may fall and rise in any order. When the FIFO-select input is high at the start of a cycle, the read is served from the FIFO whatever the upper address bits are. The two lowest address bits rotate the delivered word by whole bytes. When FIFO-select is low, the read goes to a stubbed register path, which returns the sampled address. The block drives a data bus and an output enable for the host-side tri-state buffer.

The FIFO side is a valid/ready stream. The source presents its head word on `rx_data_i` with `rx_valid_i` high. It must hold both stable until a transfer: a clock edge at which `rx_ready_o` and `rx_valid_i` are both high. `rx_ready_o` is a one-clock pulse issued after a FIFO read cycle ends, and only for a word that was latched at that cycle's start. The port therefore applies back-pressure simply by not asserting ready, and never asserts ready toward an empty source.

Strobe timing is checked in clocks. A violation sets a sticky protocol-error flag. A read from an empty FIFO sets a sticky underflow flag. Only reset clears either flag.

Top module: `host_fifo_rd_port`

## Requirements
- R1: A read cycle begins only when both `cs_n_i` and `rd_n_i` are low. `host_oe_o` rises on the third rising clock edge after both are low. It stays low while only one of them is low.
- R2: A cycle ends as soon as either strobe goes high, in any order. `host_oe_o` falls on the third rising edge after the first release.
- R3: In FIFO mode (`fifo_sel_i`=1), the returned word is the FIFO head rotated right by 8×`addr_i[1:0]` bits. `addr_i[6:2]` (host address bits 7:3) has no effect.
- R4: In register mode (`fifo_sel_i`=0), the returned word is `addr_i` zero-extended, and the FIFO is never popped.
- R5: Each completed FIFO-mode cycle with data available pops exactly one word. The pop is a single-clock `rx_ready_o` pulse issued after the cycle ends and never while `host_oe_o` is high. Back-to-back cycles are unlimited in number.
- R6: A FIFO-mode read while `rx_valid_i` is low returns zero, does not pop, and sets `underflow_o`, which stays high until reset.
- R7: `host_oe_o` is high only during a cycle. `host_data_o` does not change while `host_oe_o` stays high.
- R8: `proto_err_o` is set, and stays set until reset, when the overlap of the strobes lasts fewer than 7 clocks, when the idle gap between cycles is shorter than 3 clocks, or when the interval from one cycle start to the next is shorter than 9 clocks. Legal timing never sets it.
- R9: A cycle cut short still pops exactly one word.
- R10: `fifo_sel_i` and `addr_i` are sampled once, at cycle start. Changing them later in the cycle does not change the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Host chip-select strobe, active low, asynchronous |
| rd_n_i | input | 1 | Host read-enable strobe, active low, asynchronous |
| fifo_sel_i | input | 1 | 1 = read from FIFO, 0 = register path |
| addr_i | input | 7 | Host address bits 7:1 |
| rx_valid_i | input | 1 | FIFO head word is valid |
| rx_data_i | input | 32 | FIFO head word |
| rx_ready_o | output | 1 | Pop pulse; a transfer happens when this and rx_valid_i are high together |
| host_data_o | output | 32 | Read data toward the host bus |
| host_oe_o | output | 1 | Enable for the host data drivers |
| underflow_o | output | 1 | Sticky: FIFO read while empty |
| proto_err_o | output | 1 | Sticky: strobe timing violated |

## Verification
Two things are decided on the same clock edge: the pop that closes a cycle and the check of that cycle's asserted time. A strobe overlap of only two clocks on a non-empty FIFO provokes both at once. That case passes if exactly one word leaves the FIFO and the error flag rises. A one-clock gap between two overlaps puts the previous cycle's pop next to the next cycle's start and the idle-time check. The bench judges it by two pops and a raised error flag. The checker also watches that the pop never coincides with an active output enable.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  // Cycle boundary events seen by the synchronized strobes
  typedef struct packed {
    logic start;
    logic stop;
  } hrp_evt_t;

  // Where a read cycle takes its data from
  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_FIFO  = 2'd1,
    SRC_EMPTY = 2'd2
  } hrp_src_e;

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int          W       = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= async_i[i];
        stab_q <= meta_q;
      end
    end
    assign sync_o[i] = stab_q;
  end

endmodule

// File: rtl/hrp_cycle_ctl.sv
module hrp_cycle_ctl
  import hrp_pkg::*;
#(
  parameter int CYC_MIN   = 9,
  parameter int ASSERT_MIN = 7,
  parameter int IDLE_MIN  = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_s_i,
  input  logic     rd_s_i,
  output hrp_evt_t evt_o,
  output logic     in_cyc_o,
  output logic     err_o
);

  localparam int LIM_MAX = (CYC_MIN > ASSERT_MIN) ?
                           ((CYC_MIN > IDLE_MIN) ? CYC_MIN : IDLE_MIN) :
                           ((ASSERT_MIN > IDLE_MIN) ? ASSERT_MIN : IDLE_MIN);
  localparam int CNT_W   = $clog2(LIM_MAX + 1) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  logic act;
  logic in_cyc_q, seen_q, err_q;
  cnt_t hi_q, lo_q, per_q;

  function automatic cnt_t sat_inc(cnt_t v);
    return (v == '1) ? v : v + cnt_t'(1);
  endfunction

  assign act         = ~cs_s_i & ~rd_s_i;
  assign evt_o.start = act & ~in_cyc_q;
  assign evt_o.stop  = ~act & in_cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cyc_q <= 1'b0;
      seen_q   <= 1'b0;
      err_q    <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      per_q    <= '0;
    end else if (evt_o.start) begin
      in_cyc_q <= 1'b1;
      seen_q   <= 1'b1;
      hi_q     <= cnt_t'(1);
      per_q    <= cnt_t'(1);
      if (seen_q && ((lo_q < cnt_t'(IDLE_MIN)) || (per_q < cnt_t'(CYC_MIN))))
        err_q <= 1'b1;
    end else if (evt_o.stop) begin
      in_cyc_q <= 1'b0;
      lo_q     <= cnt_t'(1);
      per_q    <= sat_inc(per_q);
      if (hi_q < cnt_t'(ASSERT_MIN))
        err_q <= 1'b1;
    end else begin
      per_q <= sat_inc(per_q);
      if (in_cyc_q) hi_q <= sat_inc(hi_q);
      else          lo_q <= sat_inc(lo_q);
    end
  end

  assign in_cyc_o = in_cyc_q;
  assign err_o    = err_q;

endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int LSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hrp_evt_t          evt_i,
  input  logic              fsel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              underflow_o
);

  localparam int LANE_W = 8;

  hrp_src_e          src;
  logic              have_q, ready_q, uf_q;
  logic [DATA_W-1:0] data_q, rot_word;

  function automatic logic [DATA_W-1:0] rot_bytes(logic [DATA_W-1:0] w,
                                                  logic [LSEL_W-1:0] s);
    logic [2*DATA_W-1:0] dbl;
    dbl = {w, w} >> (LANE_W * s);
    return dbl[DATA_W-1:0];
  endfunction

  assign rot_word = rot_bytes(rx_data_i, addr_i[LSEL_W-1:0]);

  always_comb begin
    if (!fsel_i)         src = SRC_REG;
    else if (rx_valid_i) src = SRC_FIFO;
    else                 src = SRC_EMPTY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      have_q  <= 1'b0;
      ready_q <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      ready_q <= evt_i.stop & have_q;
      if (evt_i.start) begin
        unique case (src)
          SRC_FIFO: begin
            data_q <= rot_word;
            have_q <= 1'b1;
          end
          SRC_EMPTY: begin
            data_q <= '0;
            have_q <= 1'b0;
            uf_q   <= 1'b1;
          end
          default: begin
            data_q <= DATA_W'(addr_i);
            have_q <= 1'b0;
          end
        endcase
      end else if (evt_i.stop) begin
        have_q <= 1'b0;
      end
    end
  end

  assign rx_ready_o  = ready_q;
  assign data_o      = data_q;
  assign underflow_o = uf_q;

endmodule

// File: rtl/host_fifo_rd_port.sv
module host_fifo_rd_port
  import hrp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 7,
  parameter int LSEL_W     = 2,
  parameter int CYC_MIN    = 9,
  parameter int ASSERT_MIN = 7,
  parameter int IDLE_MIN   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              fifo_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_oe_o,
  output logic              underflow_o,
  output logic              proto_err_o
);

  logic [1:0] strb_s;
  hrp_evt_t   evt;

  hrp_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_n_i, rd_n_i}),
    .sync_o (strb_s)
  );

  hrp_cycle_ctl #(
    .CYC_MIN   (CYC_MIN),
    .ASSERT_MIN(ASSERT_MIN),
    .IDLE_MIN  (IDLE_MIN)
  ) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_i  (strb_s[1]),
    .rd_s_i  (strb_s[0]),
    .evt_o   (evt),
    .in_cyc_o(host_oe_o),
    .err_o   (proto_err_o)
  );

  hrp_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LSEL_W(LSEL_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .fsel_i     (fifo_sel_i),
    .addr_i     (addr_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .data_o     (host_data_o),
    .underflow_o(underflow_o)
  );

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              rd_n_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic [DATA_W-1:0] host_data_o,
  input logic              host_oe_o,
  input logic              underflow_o,
  input logic              proto_err_o
);

  AST_OE_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_oe_o) |-> $past(!cs_n_i && !rd_n_i, 2)); // R1

  AST_POP_OUTSIDE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !host_oe_o); // R5

  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |=> !rx_ready_o); // R5

  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> rx_valid_i); // R6

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R6

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_oe_o && $past(host_oe_o)) |-> $stable(host_data_o)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R8

endmodule

bind host_fifo_rd_port hrp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .rd_n_i     (rd_n_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .host_data_o(host_data_o),
  .host_oe_o  (host_oe_o),
  .underflow_o(underflow_o),
  .proto_err_o(proto_err_o)
);

// File: tb/tb_host_fifo_rd_port.sv
`timescale 1ns/1ps
module tb_host_fifo_rd_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, fsel = 1'b1;
  logic [6:0]  addr = '0;
  logic        rx_valid, rx_ready, oe, uf, perr;
  logic [31:0] rx_data, data;

  logic [31:0] mem [0:63];
  int wr_ptr = 0, rd_ptr = 0, pops = 0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  assign rx_valid = (wr_ptr != rd_ptr);
  assign rx_data  = mem[rd_ptr % 64];

  // FIFO source model: advances on a transfer edge
  always @(posedge clk) begin
    if (rx_ready && rx_valid) begin
      rd_ptr <= rd_ptr + 1;
      pops   <= pops + 1;
    end
  end

  host_fifo_rd_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n),
    .fifo_sel_i(fsel), .addr_i(addr), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .host_data_o(data),
    .host_oe_o(oe), .underflow_o(uf), .proto_err_o(perr)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rot(input logic [31:0] w, input logic [1:0] s);
    int sh;
    sh = 8 * s;
    return (sh == 0) ? w : ((w >> sh) | (w << (32 - sh)));
  endfunction

  task automatic push(input logic [31:0] w);
    mem[wr_ptr % 64] = w;
    wr_ptr++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // mode 0: strobes together; 1: cs leads, rd released first; 2: rd leads, cs released first
  task automatic do_read(input string req, input logic fs, input logic [6:0] ad,
                         input int lo, input int hi, input int mode,
                         input logic [31:0] exp_d, input int exp_pop, input bit wiggle);
    int p0;
    logic [31:0] mid;
    p0 = pops;
    fsel = fs; addr = ad;
    case (mode)
      1: begin cs_n = 1'b0; @(negedge clk); rd_n = 1'b0; end
      2: begin rd_n = 1'b0; @(negedge clk); cs_n = 1'b0; end
      default: begin cs_n = 1'b0; rd_n = 1'b0; end
    endcase
    repeat (4) @(negedge clk);
    chk(oe == 1'b1, {req, " oe in cycle"}, 32'(oe), 32'd1);
    chk(data == exp_d, {req, " data"}, data, exp_d);
    mid = data;
    if (wiggle) begin fsel = ~fs; addr = ~ad; end
    repeat (lo - 4) @(negedge clk);
    chk(data == mid, {req, " R7 data held"}, data, mid);
    case (mode)
      1: begin rd_n = 1'b1; @(negedge clk); cs_n = 1'b1; repeat (hi - 1) @(negedge clk); end
      2: begin cs_n = 1'b1; @(negedge clk); rd_n = 1'b1; repeat (hi - 1) @(negedge clk); end
      default: begin cs_n = 1'b1; rd_n = 1'b1; repeat (hi) @(negedge clk); end
    endcase
    chk(oe == 1'b0, {req, " R2 oe off after end"}, 32'(oe), 32'd0);
    if (exp_pop >= 0)
      chk(pops - p0 == exp_pop, {req, " pop count"}, 32'(pops - p0), 32'(exp_pop));
    fsel = fs;
  endtask

  task automatic t_reset_state();
    chk(oe == 0 && rx_ready == 0 && uf == 0 && perr == 0, "R7 reset state",
        {28'd0, oe, rx_ready, uf, perr}, 32'd0);
  endtask

  task automatic t_single_strobe();
    int p0;
    bit seen_oe;
    p0 = pops; seen_oe = 0;
    push(32'hA5A5_0001);
    cs_n = 1'b0;
    repeat (10) begin @(negedge clk); seen_oe |= oe; end
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (10) begin @(negedge clk); seen_oe |= oe; end
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!seen_oe, "R1 one strobe alone starts no cycle", 32'(seen_oe), 32'd0);
    chk(pops == p0, "R1 one strobe alone pops nothing", 32'(pops - p0), 32'd0);
  endtask

  task automatic t_orders();
    push(32'h1122_3344);
    push(32'h5566_7788);
    do_read("R2 mode1 R5", 1'b1, 7'h00, 8, 6, 1, 32'hA5A5_0001, 1, 0);
    do_read("R2 mode1 R5", 1'b1, 7'h00, 8, 6, 1, 32'h1122_3344, 1, 0);
    do_read("R2 mode2 R5", 1'b1, 7'h00, 8, 6, 2, 32'h5566_7788, 1, 0);
  endtask

  task automatic t_address();
    push(32'hDEAD_BEEF);
    push(32'h0102_0304);
    push(32'hCAFE_F00D);
    push(32'h89AB_CDEF);
    do_read("R3 upper ignored", 1'b1, 7'b1011100, 8, 6, 0, 32'hDEAD_BEEF, 1, 0);
    do_read("R3 rot1", 1'b1, 7'b1111101, 8, 6, 0, rot(32'h0102_0304, 2'd1), 1, 0);
    do_read("R3 rot2", 1'b1, 7'b0100110, 8, 6, 0, rot(32'hCAFE_F00D, 2'd2), 1, 0);
    do_read("R3 rot3", 1'b1, 7'b0000011, 8, 6, 0, rot(32'h89AB_CDEF, 2'd3), 1, 0);
  endtask

  task automatic t_register();
    push(32'h7777_0000);
    do_read("R4 register path", 1'b0, 7'h35, 8, 6, 0, 32'h0000_0035, 0, 0);
    do_read("R4 register path", 1'b0, 7'h4A, 8, 6, 2, 32'h0000_004A, 0, 0);
    chk(rx_valid && rx_data == 32'h7777_0000, "R4 FIFO untouched", rx_data, 32'h7777_0000);
  endtask

  task automatic t_late_change();
    do_read("R10 late fsel/addr change", 1'b1, 7'h00, 8, 6, 0, 32'h7777_0000, 1, 1);
  endtask

  task automatic t_burst();
    int p0;
    p0 = pops;
    for (int i = 0; i < 8; i++) push(32'hB000_0000 + 32'(i));
    for (int i = 0; i < 8; i++)
      do_read("R5 burst", 1'b1, 7'h00, 7, 3, i % 3, 32'hB000_0000 + 32'(i), -1, 0);
    repeat (4) @(negedge clk);
    chk(pops - p0 == 8, "R5 burst pops one per cycle", 32'(pops - p0), 32'd8);
    chk(perr == 1'b0, "R8 minimum legal timing raises no error", 32'(perr), 32'd0);
  endtask

  task automatic t_underflow();
    chk(rx_valid == 1'b0, "R6 precondition empty", 32'(rx_valid), 32'd0);
    do_read("R6 empty read", 1'b1, 7'h01, 8, 6, 0, 32'h0, 0, 0);
    chk(uf == 1'b1, "R6 underflow set", 32'(uf), 32'd1);
    push(32'h600D_600D);
    do_read("R6 read after refill", 1'b1, 7'h00, 8, 6, 0, 32'h600D_600D, 1, 0);
    chk(uf == 1'b1, "R6 underflow sticky", 32'(uf), 32'd1);
  endtask

  task automatic t_short_assert();
    int p0;
    do_reset();
    chk(perr == 1'b0 && uf == 1'b0, "R8 flags clear after reset", {30'd0, perr, uf}, 32'd0);
    push(32'h5407_0001);
    p0 = pops;
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(pops - p0 == 1, "R9 aborted cycle pops once", 32'(pops - p0), 32'd1);
    chk(perr == 1'b1, "R8 short assertion flagged", 32'(perr), 32'd1);
  endtask

  task automatic t_short_idle();
    int p0;
    do_reset();
    push(32'h1D1E_0001);
    push(32'h1D1E_0002);
    p0 = pops;
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (7) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b0;
    repeat (7) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(pops - p0 == 2, "R5 two cycles around a short gap pop twice", 32'(pops - p0), 32'd2);
    chk(perr == 1'b1, "R8 short idle flagged", 32'(perr), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_single_strobe();
    t_orders();
    t_address();
    t_register();
    t_late_change();
    t_burst();
    t_underflow();
    t_short_assert();
    t_short_idle();
    summary();
    $finish;
  end

endmodule